// File: doc/BRIEF.md
# Serial Management Bus Transaction Sequencer

This block runs complete transactions on a two-wire serial management bus made of a clock line, which the block always drives, and a shared data line. It sends no bits itself. It starts a separate frame transmitter and a separate response receiver over start/done handshakes. For each of them it supplies the bus clock and a one-cycle bit tick. Between their phases it drives the data line high itself: the echo gap after each frame, the idle gap before each poll, and the priming gap after each response. It also produces the fixed-length sequences for start-up and link reset.

The host raises `req_i` for one cycle while the block is idle. With `req_brk_i` low, the request runs a command transaction. With it high, it runs a link-reset (break) sequence. The slave may answer BUSY. In that case the block idles the bus, sends a poll frame and listens again, up to a retry limit. Past that limit it sends a terminate frame and reports that the slave is stuck. Each request ends with a one-cycle `done_o` that carries a status code. The bus clock period is `2*CLK_DIV` system cycles. All gap lengths are parameters. The values quoted below are the defaults.

Top module: `serial_txn_seq`

## Requirements
- R1: While reset is held, and afterwards until start-up ends, `busy_o` is 1 and the block owns the data line and drives it high. After reset the bus clock makes INIT_CLKS (5000) rising edges with data high. `busy_o` then drops.
- R2: While idle, `bclk_o`, `sdat_o` and `sdat_own_o` are all 1 and the bus clock does not toggle.
- R3: A request is taken only in the idle state. A `req_i` pulse during a transaction or a break starts nothing and adds no `done_o`. `req_brk_i` = 1 selects a break and 0 selects a command transaction.
- R4: A break drives data high for BRK_PRE_CLKS (50) rising edges, then low for BRK_LOW_CLKS (256), then high for ECHO_CLKS plus BRK_POST_CLKS (16 + 16000). It then ends with status 0.
- R5: A transaction opens with a one-cycle `tx_start_o`, with `tx_kind_o` = 0 (command), and releases the line while the frame is sent and the response is read. After `tx_done_i`, the line is held high for ECHO_CLKS (16) rising edges. `rx_start_o` then pulses for one cycle.
- R6: A response tag of 0 (ACK) ends with status 0. Tag 2 ends with status 2. Tag 3 ends with status 3.
- R7: `rx_tmo_i` ends with status 4. `rx_crc_err_i` alone ends with status 5. A timeout takes priority over a CRC error.
- R8: A response tag of 1 (BUSY) leads to GAP_CLKS (100) rising edges with data high. A frame with `tx_kind_o` = 1 (poll) follows, then the echo gap and a new response.
- R9: After MAX_BUSY (100) polls, the next BUSY response leads to the same gap and then a frame with `tx_kind_o` = 2 (terminate). A clean ACK to it gives status 1. Any other tag, a timeout or a CRC error gives status 6.
- R10: After the final response of every transaction, whatever its outcome, the line is held high for PRIME_CLKS (100) rising edges before `done_o`.
- R11: `done_o` lasts one cycle, and `status_o` is valid with it. `busy_o` stays 1 through that cycle and is 0 in the next one.
- R12: `bit_tick_o` is high exactly in the cycles where `bclk_o` has just risen.

States: INIT, IDLE, BRK_PRE, BRK_LOW, BRK_ECHO, BRK_POST, SEND_GO, SEND_WAIT, ECHO, RECV_GO, RECV_WAIT, BUSY_GAP, PRIME, FINISH. Transitions:
- INIT→IDLE when the start-up count expires.
- IDLE→BRK_PRE on a break request. IDLE→SEND_GO on a command request.
- The break states chain to FINISH, each one leaving when its count expires.
- SEND_GO→SEND_WAIT unconditionally. SEND_WAIT→ECHO on `tx_done_i`.
- ECHO→RECV_GO when the echo count expires. RECV_GO→RECV_WAIT unconditionally.
- RECV_WAIT→BUSY_GAP on a BUSY response to a command or poll frame. RECV_WAIT→PRIME otherwise.
- BUSY_GAP→SEND_GO with a poll or terminate frame.
- PRIME→FINISH when the priming count expires. FINISH→IDLE unconditionally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request pulse, taken only when idle |
| req_brk_i | input | 1 | 1 = break sequence, 0 = command transaction |
| busy_o | output | 1 | Block is starting up or running a request |
| done_o | output | 1 | One-cycle end-of-request strobe |
| status_o | output | 3 | Result code, valid with `done_o` |
| bclk_o | output | 1 | Bus clock line |
| sdat_o | output | 1 | Data level driven by the sequencer |
| sdat_own_o | output | 1 | 1 while the sequencer drives the data line |
| bit_tick_o | output | 1 | One-cycle pulse on each bus clock rise |
| tx_start_o | output | 1 | Start the frame transmitter |
| tx_kind_o | output | 2 | Frame to send: 0 command, 1 poll, 2 terminate |
| tx_done_i | input | 1 | Frame transmitter finished |
| rx_start_o | output | 1 | Start the response receiver |
| rx_done_i | input | 1 | Response receiver finished |
| rx_tag_i | input | 2 | Response tag: 0 ACK, 1 BUSY, 2 ERRA, 3 ERRC |
| rx_tmo_i | input | 1 | Receiver saw no start bit in time |
| rx_crc_err_i | input | 1 | Receiver found a bad response CRC |

## Verification
Each gap is counted in bus clock rises, measured from the handshake that opens it. The first rise counted is the one at or after the cycle that follows `tx_done_i` or `rx_done_i`. The strobe that closes the gap comes one system cycle after the last counted rise: `rx_start_o` after the echo gap, `tx_start_o` after the busy gap, `done_o` after the priming gap. No extra rise can fall in that cycle. The bench counts rises on the falling system edge. It drives the handshakes one time unit after the rising edge, clears its counter on the handshake and latches the count on the closing strobe, so every expected value is the gap length exactly. `status_o` is read in the cycle `done_o` is high, and `busy_o` is checked one cycle later.

// File: rtl/txn_seq_pkg.sv
package txn_seq_pkg;

    typedef enum logic [3:0] {
        ST_INIT, ST_IDLE, ST_BRK_PRE, ST_BRK_LOW, ST_BRK_ECHO, ST_BRK_POST,
        ST_SEND_GO, ST_SEND_WAIT, ST_ECHO, ST_RECV_GO, ST_RECV_WAIT,
        ST_BUSY_GAP, ST_PRIME, ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_POLL = 2'd1,
        KIND_TERM = 2'd2
    } frame_kind_e;

    typedef enum logic [2:0] {
        STAT_OK    = 3'd0,
        STAT_STUCK = 3'd1,
        STAT_ERRA  = 3'd2,
        STAT_ERRC  = 3'd3,
        STAT_TMO   = 3'd4,
        STAT_CRC   = 3'd5,
        STAT_LOST  = 3'd6
    } txn_status_e;

    localparam logic [1:0] TAG_ACK  = 2'd0;
    localparam logic [1:0] TAG_BUSY = 2'd1;
    localparam logic [1:0] TAG_ERRA = 2'd2;
    localparam logic [1:0] TAG_ERRC = 2'd3;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_bus_clk.sv
module seq_bus_clk #(
    parameter int unsigned CLK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic bclk_o,
    output logic tick_o
);
    localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

    logic [DW-1:0] div_q;

    // Half-period divider; the line parks high whenever the bus is not clocked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bclk_o <= 1'b1;
            tick_o <= 1'b0;
        end else if (!run_i) begin
            div_q  <= '0;
            bclk_o <= 1'b1;
            tick_o <= 1'b0;
        end else if (div_q == DIV_LAST) begin
            div_q  <= '0;
            bclk_o <= ~bclk_o;
            tick_o <= ~bclk_o;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
    parameter int unsigned CW      = 8,
    parameter int unsigned RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          tick_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(RST_VAL);
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Fires on the bus clock rise that completes the loaded count.
    assign expire_o = tick_i && (cnt_q == CW'(1));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import txn_seq_pkg::*;
#(
    parameter int unsigned CW            = 14,
    parameter int unsigned BRK_PRE_CLKS  = 50,
    parameter int unsigned BRK_LOW_CLKS  = 256,
    parameter int unsigned ECHO_CLKS     = 16,
    parameter int unsigned BRK_POST_CLKS = 16000,
    parameter int unsigned GAP_CLKS      = 100,
    parameter int unsigned PRIME_CLKS    = 100,
    parameter int unsigned MAX_BUSY      = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          req_brk_i,
    input  logic          expire_i,
    input  logic          tx_done_i,
    input  logic          rx_done_i,
    input  logic [1:0]    rx_tag_i,
    input  logic          rx_tmo_i,
    input  logic          rx_crc_err_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [2:0]    status_o,
    output logic          sdat_o,
    output logic          own_o,
    output logic          tx_start_o,
    output logic [1:0]    tx_kind_o,
    output logic          rx_start_o,
    output logic          run_o,
    output logic          load_o,
    output logic [CW-1:0] load_val_o
);
    localparam int unsigned BW = $clog2(MAX_BUSY + 1);

    seq_state_e  state_q, state_n;
    frame_kind_e kind_q, kind_n;
    txn_status_e stat_q, stat_n;
    logic [BW-1:0] bcnt_q, bcnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            kind_q  <= KIND_CMD;
            stat_q  <= STAT_OK;
            bcnt_q  <= '0;
        end else begin
            state_q <= state_n;
            kind_q  <= kind_n;
            stat_q  <= stat_n;
            bcnt_q  <= bcnt_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        kind_n  = kind_q;
        stat_n  = stat_q;
        bcnt_n  = bcnt_q;
        unique case (state_q)
            ST_INIT:      if (expire_i) state_n = ST_IDLE;
            ST_IDLE: begin
                if (req_i) begin
                    bcnt_n = '0;
                    stat_n = STAT_OK;
                    kind_n = KIND_CMD;
                    state_n = req_brk_i ? ST_BRK_PRE : ST_SEND_GO;
                end
            end
            ST_BRK_PRE:   if (expire_i) state_n = ST_BRK_LOW;
            ST_BRK_LOW:   if (expire_i) state_n = ST_BRK_ECHO;
            ST_BRK_ECHO:  if (expire_i) state_n = ST_BRK_POST;
            ST_BRK_POST:  if (expire_i) state_n = ST_FINISH;
            ST_SEND_GO:   state_n = ST_SEND_WAIT;
            ST_SEND_WAIT: if (tx_done_i) state_n = ST_ECHO;
            ST_ECHO:      if (expire_i) state_n = ST_RECV_GO;
            ST_RECV_GO:   state_n = ST_RECV_WAIT;
            ST_RECV_WAIT: begin
                if (rx_done_i) begin
                    state_n = ST_PRIME;
                    if (kind_q == KIND_TERM) begin
                        stat_n = (!rx_tmo_i && !rx_crc_err_i && rx_tag_i == TAG_ACK)
                                 ? STAT_STUCK : STAT_LOST;
                    end else if (rx_tmo_i) begin
                        stat_n = STAT_TMO;
                    end else if (rx_crc_err_i) begin
                        stat_n = STAT_CRC;
                    end else begin
                        unique case (rx_tag_i)
                            TAG_ACK:  stat_n = STAT_OK;
                            TAG_BUSY: state_n = ST_BUSY_GAP;
                            TAG_ERRA: stat_n = STAT_ERRA;
                            TAG_ERRC: stat_n = STAT_ERRC;
                            default:  stat_n = STAT_ERRA;
                        endcase
                    end
                end
            end
            ST_BUSY_GAP: begin
                if (expire_i) begin
                    state_n = ST_SEND_GO;
                    if (bcnt_q < BW'(MAX_BUSY)) begin
                        kind_n = KIND_POLL;
                        bcnt_n = bcnt_q + 1'b1;
                    end else begin
                        kind_n = KIND_TERM;
                    end
                end
            end
            ST_PRIME:     if (expire_i) state_n = ST_FINISH;
            ST_FINISH:    state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_FINISH);
        status_o   = stat_q;
        tx_kind_o  = kind_q;
        tx_start_o = (state_q == ST_SEND_GO);
        rx_start_o = (state_q == ST_RECV_GO);
        own_o      = !(state_q inside {ST_SEND_GO, ST_SEND_WAIT, ST_RECV_GO, ST_RECV_WAIT});
        sdat_o     = (state_q != ST_BRK_LOW);
        run_o      = !(state_n inside {ST_IDLE, ST_FINISH});
        load_o     = 1'b0;
        load_val_o = '0;
        if (state_n != state_q) begin
            unique case (state_n)
                ST_BRK_PRE:  begin load_o = 1'b1; load_val_o = CW'(BRK_PRE_CLKS);  end
                ST_BRK_LOW:  begin load_o = 1'b1; load_val_o = CW'(BRK_LOW_CLKS);  end
                ST_BRK_ECHO: begin load_o = 1'b1; load_val_o = CW'(ECHO_CLKS);     end
                ST_BRK_POST: begin load_o = 1'b1; load_val_o = CW'(BRK_POST_CLKS); end
                ST_ECHO:     begin load_o = 1'b1; load_val_o = CW'(ECHO_CLKS);     end
                ST_BUSY_GAP: begin load_o = 1'b1; load_val_o = CW'(GAP_CLKS);      end
                ST_PRIME:    begin load_o = 1'b1; load_val_o = CW'(PRIME_CLKS);    end
                default:     begin load_o = 1'b0; load_val_o = '0;                 end
            endcase
        end
    end
endmodule

// File: rtl/serial_txn_seq.sv
module serial_txn_seq
    import txn_seq_pkg::*;
#(
    parameter int unsigned CLK_DIV       = 1,
    parameter int unsigned INIT_CLKS     = 5000,
    parameter int unsigned BRK_PRE_CLKS  = 50,
    parameter int unsigned BRK_LOW_CLKS  = 256,
    parameter int unsigned ECHO_CLKS     = 16,
    parameter int unsigned BRK_POST_CLKS = 16000,
    parameter int unsigned GAP_CLKS      = 100,
    parameter int unsigned PRIME_CLKS    = 100,
    parameter int unsigned MAX_BUSY      = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       req_brk_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [2:0] status_o,
    output logic       bclk_o,
    output logic       sdat_o,
    output logic       sdat_own_o,
    output logic       bit_tick_o,
    output logic       tx_start_o,
    output logic [1:0] tx_kind_o,
    input  logic       tx_done_i,
    output logic       rx_start_o,
    input  logic       rx_done_i,
    input  logic [1:0] rx_tag_i,
    input  logic       rx_tmo_i,
    input  logic       rx_crc_err_i
);
    localparam int unsigned MAXC = umax(umax(umax(INIT_CLKS, BRK_POST_CLKS),
                                             umax(BRK_PRE_CLKS, BRK_LOW_CLKS)),
                                        umax(umax(ECHO_CLKS, GAP_CLKS), PRIME_CLKS));
    localparam int unsigned CW = $clog2(MAXC + 1);

    logic          run, tick, expire, load;
    logic [CW-1:0] load_val;

    seq_bus_clk #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .bclk_o (bclk_o),
        .tick_o (tick)
    );

    seq_gap_timer #(.CW(CW), .RST_VAL(INIT_CLKS)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .tick_i     (tick),
        .expire_o   (expire)
    );

    seq_ctrl #(
        .CW(CW), .BRK_PRE_CLKS(BRK_PRE_CLKS), .BRK_LOW_CLKS(BRK_LOW_CLKS),
        .ECHO_CLKS(ECHO_CLKS), .BRK_POST_CLKS(BRK_POST_CLKS), .GAP_CLKS(GAP_CLKS),
        .PRIME_CLKS(PRIME_CLKS), .MAX_BUSY(MAX_BUSY)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .req_brk_i    (req_brk_i),
        .expire_i     (expire),
        .tx_done_i    (tx_done_i),
        .rx_done_i    (rx_done_i),
        .rx_tag_i     (rx_tag_i),
        .rx_tmo_i     (rx_tmo_i),
        .rx_crc_err_i (rx_crc_err_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .status_o     (status_o),
        .sdat_o       (sdat_o),
        .own_o        (sdat_own_o),
        .tx_start_o   (tx_start_o),
        .tx_kind_o    (tx_kind_o),
        .rx_start_o   (rx_start_o),
        .run_o        (run),
        .load_o       (load),
        .load_val_o   (load_val)
    );

    assign bit_tick_o = tick;
endmodule

// File: rtl/serial_txn_seq_chk.sv
module serial_txn_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic [2:0] status_o,
    input logic       bclk_o,
    input logic       sdat_o,
    input logic       sdat_own_o,
    input logic       bit_tick_o,
    input logic       tx_start_o,
    input logic       rx_start_o
);
    logic started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       started_q <= 1'b0;
        else if (!busy_o) started_q <= 1'b1;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R11
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && busy_o && !done_o) |=> busy_o); // R3
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o <= 3'd6)); // R11
    AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_start_o && rx_start_o)); // R5
    AST_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start_o || rx_start_o) |-> !sdat_own_o); // R5
    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (bclk_o && sdat_o && sdat_own_o)); // R2
    AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> (bclk_o && !$past(bclk_o))); // R12
    AST_LOW_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        !sdat_o |-> (sdat_own_o && busy_o)); // R4
endmodule

bind serial_txn_seq serial_txn_seq_chk u_chk (.*);

// File: tb/tb_serial_txn_seq.sv
`timescale 1ns/1ps
module tb_serial_txn_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_brk = 1'b0;
    logic tx_done = 1'b0, rx_done = 1'b0;
    logic [1:0] rx_tag = 2'd0;
    logic rx_tmo = 1'b0, rx_crc = 1'b0;
    logic busy_o, done_o, bclk_o, sdat_o, sdat_own_o, bit_tick_o, tx_start_o, rx_start_o;
    logic [2:0] status_o;
    logic [1:0] tx_kind_o;

    always #2 clk = ~clk;

    serial_txn_seq dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_brk_i(req_brk),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
        .bclk_o(bclk_o), .sdat_o(sdat_o), .sdat_own_o(sdat_own_o),
        .bit_tick_o(bit_tick_o), .tx_start_o(tx_start_o), .tx_kind_o(tx_kind_o),
        .tx_done_i(tx_done), .rx_start_o(rx_start_o), .rx_done_i(rx_done),
        .rx_tag_i(rx_tag), .rx_tmo_i(rx_tmo), .rx_crc_err_i(rx_crc)
    );

    int n_checks = 0, n_fail = 0;
    // scripted responder settings
    int busy_left = 0;
    logic [1:0] rsp_tag = 2'd0;
    bit rsp_tmo = 0, rsp_crc = 0, term_ok = 1;
    logic [1:0] last_kind = 2'd0;
    // monitor state
    bit pb = 1'b1, pdone = 1'b0;
    int tot_rise = 0, init_low = 0;
    int echo_cnt = 0, echo_seen = -1, post_cnt = 0, prime_seen = -1;
    int pgap_min = 1000000, pgap_max = -1;
    int n_cmd = 0, n_poll = 0, n_term = 0, n_done = 0, done_wide = 0, tick_bad = 0;
    int brk_h1 = 0, brk_l = 0, brk_h2 = 0;
    bit seen_low = 0;

    task automatic check(string rq, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // falling-edge monitor
    always @(negedge clk) begin
        automatic bit rise = bclk_o && !pb;
        pb = bclk_o;
        if (rise) tot_rise++;
        if (rise && busy_o && sdat_own_o) begin
            if (!sdat_o) begin brk_l++; seen_low = 1; end
            else if (!seen_low) brk_h1++;
            else brk_h2++;
        end
        if (rise && !sdat_o) init_low++;
        if (bit_tick_o != rise) tick_bad++;
        if (tx_done) echo_cnt = 0; else if (rise) echo_cnt++;
        if (rx_start_o) echo_seen = echo_cnt;
        if (rx_done) post_cnt = 0; else if (rise) post_cnt++;
        if (tx_start_o) begin
            if (tx_kind_o == 2'd0) n_cmd++;
            else begin
                if (tx_kind_o == 2'd1) n_poll++; else n_term++;
                if (post_cnt < pgap_min) pgap_min = post_cnt;
                if (post_cnt > pgap_max) pgap_max = post_cnt;
            end
        end
        if (done_o) begin prime_seen = post_cnt; n_done++; end
        if (done_o && pdone) done_wide++;
        pdone = done_o;
    end

    // frame transmitter model
    initial forever begin
        @(posedge clk); #1;
        if (tx_start_o) begin
            automatic int n = 0;
            last_kind = tx_kind_o;
            while (n < 8) begin @(posedge clk); #1; if (bit_tick_o) n++; end
            tx_done = 1'b1;
            @(posedge clk); #1;
            tx_done = 1'b0;
        end
    end

    // response receiver model
    initial forever begin
        @(posedge clk); #1;
        if (rx_start_o) begin
            automatic int n = 0;
            while (n < 6) begin @(posedge clk); #1; if (bit_tick_o) n++; end
            if (last_kind == 2'd2) begin
                rx_tag = term_ok ? 2'd0 : 2'd2; rx_tmo = 0; rx_crc = 0;
            end else if (busy_left > 0) begin
                rx_tag = 2'd1; rx_tmo = 0; rx_crc = 0; busy_left--;
            end else begin
                rx_tag = rsp_tag; rx_tmo = rsp_tmo; rx_crc = rsp_crc;
            end
            rx_done = 1'b1;
            @(posedge clk); #1;
            rx_done = 1'b0;
        end
    end

    task automatic start_req(bit brk);
        @(posedge clk); #1;
        req = 1'b1; req_brk = brk;
        @(posedge clk); #1;
        req = 1'b0; req_brk = 1'b0;
    endtask

    task automatic wait_done(output int st);
        while (!done_o) begin @(posedge clk); #1; end
        st = int'(status_o);
        @(posedge clk); #1;
        check("R11 busy low after done", int'(busy_o), 0);
    endtask

    task automatic t_init();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 busy in reset", int'(busy_o), 1);
        check("R1 data owned high in reset", int'(sdat_o && sdat_own_o && bclk_o), 1);
        tot_rise = 0; init_low = 0;
        rst_n = 1'b1;
        while (busy_o) begin @(posedge clk); #1; end
        check("R1 start-up rises", tot_rise, 5000);
        check("R1 data high in start-up", init_low, 0);
        repeat (10) @(posedge clk); #1;
        check("R2 idle clock parked", tot_rise, 5000);
        check("R2 idle lines high", int'(bclk_o && sdat_o && sdat_own_o), 1);
    endtask

    task automatic t_break();
        int st;
        brk_h1 = 0; brk_l = 0; brk_h2 = 0; seen_low = 0;
        start_req(1'b1);
        wait_done(st);
        check("R4 break pre-high", brk_h1, 50);
        check("R4 break low", brk_l, 256);
        check("R4 break post-high", brk_h2, 16016);
        check("R4 break status", st, 0);
        check("R2 idle after break", int'(bclk_o && sdat_o && sdat_own_o), 1);
    endtask

    task automatic t_resp(string rq, logic [1:0] tag, bit tmo, bit crc, int nbusy, int exp_st);
        int st, c0, p0, d0;
        rsp_tag = tag; rsp_tmo = tmo; rsp_crc = crc; busy_left = nbusy;
        pgap_min = 1000000; pgap_max = -1; echo_seen = -1;
        c0 = n_cmd; p0 = n_poll; d0 = n_done;
        start_req(1'b0);
        wait_done(st);
        check(rq, st, exp_st);
        check("R5 one command frame", n_cmd - c0, 1);
        check("R5 echo gap", echo_seen, 16);
        check("R10 priming gap", prime_seen, 100);
        check("R11 one done", n_done - d0, 1);
        if (nbusy > 0) begin
            check("R8 poll count", n_poll - p0, nbusy);
            check("R8 busy gap min", pgap_min, 100);
            check("R8 busy gap max", pgap_max, 100);
        end
    endtask

    task automatic t_stuck(bit ok, int exp_st);
        int st, p0, t0;
        term_ok = ok; busy_left = 100000; rsp_tag = 0; rsp_tmo = 0; rsp_crc = 0;
        pgap_min = 1000000; pgap_max = -1;
        p0 = n_poll; t0 = n_term;
        start_req(1'b0);
        wait_done(st);
        busy_left = 0;
        check("R9 stuck status", st, exp_st);
        check("R9 polls before terminate", n_poll - p0, 100);
        check("R9 one terminate", n_term - t0, 1);
        check("R9 gap before terminate", pgap_max, 100);
        check("R10 priming after terminate", prime_seen, 100);
    endtask

    task automatic t_ignore();
        int st, c0, d0;
        rsp_tag = 0; rsp_tmo = 0; rsp_crc = 0; busy_left = 0;
        c0 = n_cmd; d0 = n_done;
        start_req(1'b0);
        repeat (20) @(posedge clk); #1;
        req = 1'b1; req_brk = 1'b1;
        @(posedge clk); #1;
        req = 1'b0; req_brk = 1'b0;
        wait_done(st);
        repeat (40) @(posedge clk); #1;
        check("R3 request in flight ignored: commands", n_cmd - c0, 1);
        check("R3 request in flight ignored: dones", n_done - d0, 1);
        check("R3 no break started", int'(busy_o), 0);
        check("R6 status with ignored request", st, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_init();
        t_break();
        t_resp("R6 ack", 2'd0, 0, 0, 0, 0);
        t_resp("R6 erra", 2'd2, 0, 0, 0, 2);
        t_resp("R6 errc", 2'd3, 0, 0, 0, 3);
        t_resp("R7 timeout", 2'd0, 1, 0, 0, 4);
        t_resp("R7 crc", 2'd0, 0, 1, 0, 5);
        t_resp("R7 timeout over crc", 2'd0, 1, 1, 0, 4);
        t_resp("R8 busy then ack", 2'd0, 0, 0, 3, 0);
        t_resp("R8 busy then errc", 2'd3, 0, 0, 1, 3);
        t_stuck(1'b1, 1);
        t_stuck(1'b0, 6);
        t_ignore();
        check("R12 tick matches rise", tick_bad, 0);
        check("R11 done width", done_wide, 0);
        summary();
        $finish;
    end
endmodule